// File: doc/BRIEF.md
# Exact-Product Dot-Product Accumulator

This block forms a running dot product of two streams of binary floating-point operands. On every cycle in which the input qualifier is high, it multiplies the two operands exactly. The significand product keeps all of its bits and is neither rounded nor normalised. The product is then aligned by its exponent and added into a wide two's-complement fixed-point register. That register is sized for the application through three parameters: the weight of its top bit, the weight of its bottom bit, and the largest weight any single product may carry.

Each operand holds a sign bit at the top, then an `EXP_W`-bit biased exponent, then an `FRAC_W`-bit fraction with an implied leading one. The product significand is `2*FRAC_W+2` bits wide and has two integer bits. Its exponent is the sum of the unbiased operand exponents. The multiply, the alignment and the addition run in a fixed three-stage pipeline. A strobe marks every cycle in which the running sum has absorbed one more qualified pair.

Three sticky flags report why a pair was left out of the sum or why the sum has wrapped. They are an operand-exception flag, a product-too-large flag and an accumulator-overflow flag. A new dot product starts from reset. Subnormal operands and conversion of the sum back to floating point are not part of the block.

Top module: `exact_sop_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first qualified pair has passed the pipeline, `acc_sum` is zero, `acc_upd` is low and all three flags are low.
- R2: Operand layout is {sign at bit OP_W-1, exponent in the next EXP_W bits, fraction in the low FRAC_W bits}, with bias 2^(EXP_W-1)-1. An exponent field of all zeros means the value zero, whatever the fraction.
- R3: For an accepted pair, `acc_sum` changes by (-1)^(sa xor sb) * floor(|a*b| * 2^(-ACC_LSB)), taken modulo 2^ACC_W. `acc_sum` is the two's-complement sum scaled by 2^(-ACC_LSB).
- R4: A pair presented with `in_valid` high at clock edge k raises `acc_upd` for exactly one cycle after edge k+2. `acc_sum` and the flags then already include that pair. Back-to-back pairs give back-to-back strobes.
- R5: Cycles with `in_valid` low change neither `acc_sum` nor the flags, and they raise no strobe, whatever the operand values.
- R6: A pair in which either operand is zero (per R2), and neither operand is an exception, leaves `acc_sum` unchanged but still raises the strobe.
- R7: Product bits of weight below 2^ACC_LSB are dropped from the magnitude before the sign is applied. Negative products are therefore truncated toward zero as well.
- R8: A pair in which either exponent field is all ones sets `exc_flag` and is not added. This takes priority over R6.
- R9: A pair of non-zero, non-exception operands whose unbiased exponent sum is MAX_IN_MSB or more sets `rng_flag` and is not added. A sum of MAX_IN_MSB-1 is accepted.
- R10: An accepted addition whose true result lies outside the signed ACC_W-bit range sets `ovf_flag`, and `acc_sum` keeps the wrapped value.
- R11: Once set, each flag stays set until reset, even while later pairs are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies the operand pair in this cycle |
| op_a | input | OP_W (32) | First operand |
| op_b | input | OP_W (32) | Second operand |
| acc_sum | output | ACC_W (101) | Two's-complement running sum scaled by 2^(-ACC_LSB) |
| acc_upd | output | 1 | One-cycle strobe: the sum has absorbed one more qualified pair |
| exc_flag | output | 1 | Sticky: an operand was infinite or not-a-number |
| rng_flag | output | 1 | Sticky: a product exceeded the allowed summand weight |
| ovf_flag | output | 1 | Sticky: the running sum wrapped |

## Verification
The accumulator register can commit an accepted product in the same cycle that a rejected pair (an exception or oversize product) or a zero pair sits one stage behind it in the pipeline. In that same cycle a new pair can also enter. The bench provokes this by streaming mixed streams with the qualifier held high, in which accepted, zero, exception and oversize pairs follow one another with no gaps. The scoreboard then judges every strobe on its own. The sum must have moved by exactly the accepted product of that slot, and each flag must have risen on the strobe of the pair that caused it and on no earlier one.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Classification of an operand pair after unpacking
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_EXC    = 2'd2,
    CLS_RANGE  = 2'd3
  } prod_cls_e;

endpackage

// File: rtl/sop_mul_stage.sv
module sop_mul_stage
  import sop_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int MAX_IN_MSB = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [EXP_W+FRAC_W:0]      op_a,
  input  logic [EXP_W+FRAC_W:0]      op_b,
  output logic                       out_valid,
  output prod_cls_e                  out_cls,
  output logic                       out_sign,
  output logic signed [EXP_W+1:0]    out_esum,
  output logic [2*FRAC_W+1:0]        out_prod
);

  localparam int OP_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ES_W   = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [ES_W-1:0] BIAS2 = ES_W'(2 * BIAS);

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              a_zero, b_zero, a_spec, b_spec;

  prod_cls_e                cls_n;
  logic                     sign_n;
  logic signed [ES_W-1:0]   esum_n;
  logic [PROD_W-1:0]        prod_n;

  prod_cls_e                cls_q;
  logic                     valid_q, sign_q;
  logic signed [ES_W-1:0]   esum_q;
  logic [PROD_W-1:0]        prod_q;

  always_comb begin
    ea     = op_a[OP_W-2 -: EXP_W];
    eb     = op_b[OP_W-2 -: EXP_W];
    fa     = op_a[FRAC_W-1:0];
    fb     = op_b[FRAC_W-1:0];
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    a_spec = (ea == '1);
    b_spec = (eb == '1);
    sign_n = op_a[OP_W-1] ^ op_b[OP_W-1];
    esum_n = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS2;
    prod_n = PROD_W'({1'b1, fa}) * PROD_W'({1'b1, fb});
    if (a_spec || b_spec)
      cls_n = CLS_EXC;
    else if (a_zero || b_zero)
      cls_n = CLS_ZERO;
    else if (int'(esum_n) >= MAX_IN_MSB)
      cls_n = CLS_RANGE;
    else
      cls_n = CLS_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_ZERO;
      sign_q  <= 1'b0;
      esum_q  <= '0;
      prod_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        cls_q  <= cls_n;
        sign_q <= sign_n;
        esum_q <= esum_n;
        prod_q <= prod_n;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_cls   = cls_q;
  assign out_sign  = sign_q;
  assign out_esum  = esum_q;
  assign out_prod  = prod_q;

  // R6
  zero_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_spec && !b_spec && (a_zero || b_zero)) |=> (out_cls == CLS_ZERO));

  // R8
  exc_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_spec || b_spec)) |=> (out_valid && out_cls == CLS_EXC));

endmodule

// File: rtl/sop_align_stage.sv
module sop_align_stage
  import sop_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int ACC_W   = 101,
  parameter int ACC_LSB = -60
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  prod_cls_e                  in_cls,
  input  logic                       in_sign,
  input  logic signed [EXP_W+1:0]    in_esum,
  input  logic [2*FRAC_W+1:0]        in_prod,
  output logic                       out_upd,
  output logic                       out_add,
  output logic [ACC_W-1:0]           out_addend,
  output logic                       out_cin,
  output logic                       out_exc,
  output logic                       out_rng
);

  localparam int PROD_W = 2 * FRAC_W + 2;
  localparam int WIDE_W = ACC_W + PROD_W;
  localparam int SH_W   = $clog2(WIDE_W + 1);

  int               pos_i;
  logic [WIDE_W-1:0] wide;
  logic [ACC_W-1:0]  mag;
  logic [ACC_W-1:0]  addend_n;

  logic              upd_q, add_q, cin_q, exc_q, rng_q;
  logic [ACC_W-1:0]  addend_q;

  always_comb begin
    // Bit position, inside the wide window, of the product LSB.
    // The window's top ACC_W bits line up with the accumulator.
    pos_i = int'(in_esum) + PROD_W - 2 * FRAC_W - ACC_LSB;
    if (pos_i < 0 || pos_i >= WIDE_W)
      wide = '0;
    else
      wide = WIDE_W'(in_prod) << pos_i[SH_W-1:0];
    mag      = wide[WIDE_W-1 -: ACC_W];
    addend_n = in_sign ? ~mag : mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q    <= 1'b0;
      add_q    <= 1'b0;
      exc_q    <= 1'b0;
      rng_q    <= 1'b0;
      cin_q    <= 1'b0;
      addend_q <= '0;
    end else begin
      upd_q <= in_valid;
      add_q <= in_valid && (in_cls == CLS_NORMAL);
      exc_q <= in_valid && (in_cls == CLS_EXC);
      rng_q <= in_valid && (in_cls == CLS_RANGE);
      if (in_valid) begin
        cin_q    <= in_sign;
        addend_q <= addend_n;
      end
    end
  end

  assign out_upd    = upd_q;
  assign out_add    = add_q;
  assign out_addend = addend_q;
  assign out_cin    = cin_q;
  assign out_exc    = exc_q;
  assign out_rng    = rng_q;

  // R9
  drop_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cls != CLS_NORMAL) |=> !out_add);

  // R5
  idle_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_upd && !out_add && !out_exc && !out_rng));

endmodule

// File: rtl/sop_accum.sv
module sop_accum #(
  parameter int ACC_W = 101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_upd,
  input  logic              in_add,
  input  logic [ACC_W-1:0]  in_addend,
  input  logic              in_cin,
  input  logic              in_exc,
  input  logic              in_rng,
  output logic [ACC_W-1:0]  sum,
  output logic              upd,
  output logic              exc_flag,
  output logic              rng_flag,
  output logic              ovf_flag
);

  logic [ACC_W:0]   ext;
  logic             wrap;
  logic [ACC_W-1:0] sum_n;
  logic             ovf_n, exc_n, rng_n;

  logic [ACC_W-1:0] sum_q;
  logic             upd_q, exc_q, rng_q, ovf_q;

  always_comb begin
    ext   = {sum_q[ACC_W-1], sum_q} + {in_addend[ACC_W-1], in_addend}
            + {{ACC_W{1'b0}}, in_cin};
    wrap  = ext[ACC_W] ^ ext[ACC_W-1];
    sum_n = in_add ? ext[ACC_W-1:0] : sum_q;
    ovf_n = ovf_q | (in_add & wrap);
    exc_n = exc_q | in_exc;
    rng_n = rng_q | in_rng;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      upd_q <= 1'b0;
      exc_q <= 1'b0;
      rng_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      upd_q <= in_upd;
      exc_q <= exc_n;
      rng_q <= rng_n;
      ovf_q <= ovf_n;
      if (in_add) sum_q <= sum_n;
    end
  end

  assign sum      = sum_q;
  assign upd      = upd_q;
  assign exc_flag = exc_q;
  assign rng_flag = rng_q;
  assign ovf_flag = ovf_q;

  // R6
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_add |=> $stable(sum));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flag || rng_flag || ovf_flag) |=>
      ((exc_flag || !$past(exc_flag)) && (rng_flag || !$past(rng_flag)) &&
       (ovf_flag || !$past(ovf_flag))));

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(in_add));

endmodule

// File: rtl/exact_sop_unit.sv
module exact_sop_unit
  import sop_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int ACC_MSB    = 40,
  parameter int MAX_IN_MSB = 16,
  parameter int ACC_LSB    = -60,
  localparam int OP_W      = 1 + EXP_W + FRAC_W,
  localparam int ACC_W     = ACC_MSB - ACC_LSB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [ACC_W-1:0]  acc_sum,
  output logic              acc_upd,
  output logic              exc_flag,
  output logic              rng_flag,
  output logic              ovf_flag
);

  localparam int PROD_W = 2 * FRAC_W + 2;
  localparam int ES_W   = EXP_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                   m_valid, m_sign;
  prod_cls_e              m_cls;
  logic signed [ES_W-1:0] m_esum;
  logic [PROD_W-1:0]      m_prod;

  logic                   a_upd, a_add, a_cin, a_exc, a_rng;
  logic [ACC_W-1:0]       a_addend;

  sop_mul_stage #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .MAX_IN_MSB(MAX_IN_MSB)
  ) mul_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(m_valid), .out_cls(m_cls), .out_sign(m_sign),
    .out_esum(m_esum), .out_prod(m_prod)
  );

  sop_align_stage #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .ACC_LSB(ACC_LSB)
  ) align_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(m_valid), .in_cls(m_cls),
    .in_sign(m_sign), .in_esum(m_esum), .in_prod(m_prod),
    .out_upd(a_upd), .out_add(a_add), .out_addend(a_addend),
    .out_cin(a_cin), .out_exc(a_exc), .out_rng(a_rng)
  );

  sop_accum #(
    .ACC_W(ACC_W)
  ) accum_i (
    .clk(clk), .rst_n(rst_int_n), .in_upd(a_upd), .in_add(a_add),
    .in_addend(a_addend), .in_cin(a_cin), .in_exc(a_exc), .in_rng(a_rng),
    .sum(acc_sum), .upd(acc_upd), .exc_flag(exc_flag),
    .rng_flag(rng_flag), .ovf_flag(ovf_flag)
  );

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |-> ##3 acc_upd);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_int_n |-> (acc_sum == '0 && !acc_upd && !exc_flag && !rng_flag && !ovf_flag));

endmodule

// File: tb/exact_sop_unit_tb_top.sv
module exact_sop_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 23;
  localparam int ACC_MSB    = 20;
  localparam int MAX_IN_MSB = 16;
  localparam int ACC_LSB    = -60;
  localparam int OP_W       = 1 + EXP_W + FRAC_W;
  localparam int ACC_W      = ACC_MSB - ACC_LSB + 1;
  localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX       = (1 << EXP_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [OP_W-1:0]  op_a = '0;
  logic [OP_W-1:0]  op_b = '0;
  logic [ACC_W-1:0] acc_sum;
  logic             acc_upd, exc_flag, rng_flag, ovf_flag;

  exact_sop_unit #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .ACC_MSB(ACC_MSB),
    .MAX_IN_MSB(MAX_IN_MSB), .ACC_LSB(ACC_LSB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_sum(acc_sum), .acc_upd(acc_upd), .exc_flag(exc_flag),
    .rng_flag(rng_flag), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [ACC_W-1:0] sum;
    logic             exc, rng, ovf;
    int               cyc;
    string            tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  logic [ACC_W-1:0] m_sum;
  logic             m_exc, m_rng, m_ovf;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [OP_W-1:0] mk(input logic s, input int e, input logic [FRAC_W-1:0] f);
    return {s, EXP_W'(e), f};
  endfunction

  // Reference model built from R2, R3, R6..R10
  task automatic model(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    int ea, eb, sh;
    logic [191:0] p, mag;
    logic signed [191:0] v, cur, nxt, hi, lo;
    ea = int'(a[OP_W-2 -: EXP_W]);
    eb = int'(b[OP_W-2 -: EXP_W]);
    if (ea == EMAX || eb == EMAX) m_exc = 1'b1;
    else if (ea == 0 || eb == 0) begin end
    else if (ea + eb - 2 * BIAS >= MAX_IN_MSB) m_rng = 1'b1;
    else begin
      p  = 192'({1'b1, a[FRAC_W-1:0]}) * 192'({1'b1, b[FRAC_W-1:0]});
      sh = ea + eb - 2 * BIAS - 2 * FRAC_W - ACC_LSB;
      mag = (sh >= 0) ? (p << sh) : (p >> (-sh));
      v   = (a[OP_W-1] ^ b[OP_W-1]) ? -$signed(mag) : $signed(mag);
      cur = $signed({{(192 - ACC_W){m_sum[ACC_W-1]}}, m_sum});
      nxt = cur + v;
      hi  = (192'sd1 <<< (ACC_W - 1)) - 192'sd1;
      lo  = -(192'sd1 <<< (ACC_W - 1));
      if (nxt > hi || nxt < lo) m_ovf = 1'b1;
      m_sum = nxt[ACC_W-1:0];
    end
  endtask

  task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    model(a, b);
    e.sum = m_sum; e.exc = m_exc; e.rng = m_rng; e.ovf = m_ovf;
    e.cyc = cyc + 3; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom;
      op_b = $urandom;
    end
  endtask

  task automatic fail_line(input string tag, input string what);
    n_err++;
    $display("FAIL %s: %s", tag, what);
  endtask

  task automatic check_state(input string tag);
    n_chk++;
    if (acc_sum !== m_sum || exc_flag !== m_exc || rng_flag !== m_rng ||
        ovf_flag !== m_ovf || acc_upd !== 1'b0)
      fail_line(tag, $sformatf("sum=%h flags=%b%b%b upd=%b exp sum=%h flags=%b%b%b upd=0",
        acc_sum, exc_flag, rng_flag, ovf_flag, acc_upd, m_sum, m_exc, m_rng, m_ovf));
  endtask

  task automatic drain(input string tag);
    idle(6);
    n_chk++;
    if (sb_q.size() != 0) fail_line(tag, $sformatf("pending=%0d exp 0", sb_q.size()));
    check_state(tag);
  endtask

  task automatic do_reset();
    mon_on = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    sb_q.delete();
    m_sum = '0; m_exc = 1'b0; m_rng = 1'b0; m_ovf = 1'b0;
    @(negedge clk);
    check_state("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release");
    mon_on = 1'b1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (acc_upd) begin
        if (sb_q.size() == 0) begin
          n_chk++;
          fail_line("R5", $sformatf("strobe with nothing expected, upd=%b exp 0", acc_upd));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          n_chk++;
          if (e.cyc != cyc)
            fail_line("R4", $sformatf("strobe at cycle %0d exp %0d", cyc, e.cyc));
          else if (acc_sum !== e.sum || exc_flag !== e.exc || rng_flag !== e.rng ||
                   ovf_flag !== e.ovf)
            fail_line(e.tag, $sformatf("sum=%h flags=%b%b%b exp sum=%h flags=%b%b%b",
              acc_sum, exc_flag, rng_flag, ovf_flag, e.sum, e.exc, e.rng, e.ovf));
        end
      end else if (sb_q.size() != 0 && sb_q[0].cyc == cyc) begin
        n_chk++;
        fail_line("R4", $sformatf("missing strobe for %s, upd=%b exp 1", sb_q[0].tag, acc_upd));
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: run did not finish, cycles=%0d exp fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_sum = '0; m_exc = 1'b0; m_rng = 1'b0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();

    // R3 basic products, back to back, mixed signs
    send(mk(0, 127, 0), mk(0, 127, 0), "R3 one*one");
    send(mk(0, 127, 23'h400000), mk(1, 128, 0), "R3 1.5*-2");
    send(mk(1, 125, 23'h123456), mk(1, 130, 23'h7ABCDE), "R3 neg*neg");
    send(mk(0, 120, 23'h0F0F0F), mk(1, 131, 23'h555555), "R3 pos*neg");
    // R5 gap with garbage operands
    idle(5);
    send(mk(0, 126, 23'h7FFFFF), mk(0, 126, 23'h7FFFFF), "R5 after gap");
    idle(3);
    // R6 zero operands (fraction ignored when exponent is zero)
    send(mk(0, 0, 23'h3FFFFF), mk(0, 140, 23'h1), "R6 zero*x");
    send(mk(1, 129, 23'h2), mk(1, 0, 0), "R6 x*-zero");
    drain("R5 drain");

    // R7 truncation below the bottom weight, both signs
    do_reset();
    send(mk(0, 107, 23'h1), mk(0, 110, 23'h1), "R7 pos trunc");
    send(mk(1, 107, 23'h1), mk(0, 110, 23'h1), "R7 neg trunc");
    send(mk(0, 87, 0), mk(0, 97, 0), "R7 fully below");
    send(mk(1, 87, 23'h7FFFFF), mk(0, 97, 23'h7FFFFF), "R7 neg fully below");
    drain("R7 drain");

    // R8 exceptions, R9 range boundary, R11 stickiness, mixed back to back
    do_reset();
    send(mk(0, 127, 0), mk(0, 128, 0), "R3 two");
    send(mk(0, 255, 0), mk(0, 127, 0), "R8 inf");
    send(mk(0, 0, 0), mk(1, 255, 23'h1), "R8 zero*nan");
    send(mk(0, 135, 0), mk(0, 135, 0), "R9 esum at limit");
    send(mk(1, 135, 23'h7FFFFF), mk(0, 134, 23'h7FFFFF), "R9 esum below limit");
    send(mk(0, 127, 23'h200000), mk(0, 127, 0), "R11 add after flags");
    drain("R11 drain");

    // R10 overflow and wrap, flag stays set
    do_reset();
    for (int i = 0; i < 24; i++)
      send(mk(0, 134, 23'h7FFFFF), mk(0, 134, 23'h7FFFFF), "R10 grow");
    send(mk(1, 127, 0), mk(0, 127, 0), "R11 ovf held");
    drain("R10 drain");

    // Mixed stream: accepted, zero, exception and oversize pairs interleaved
    do_reset();
    for (int i = 0; i < 60; i++) begin
      int ea, eb;
      ea = 110 + int'($urandom % 30);
      eb = 110 + int'($urandom % 30);
      if (i % 7 == 3) ea = 0;
      if (i % 13 == 9) eb = EMAX;
      send(mk(1'($urandom), ea, 23'($urandom)), mk(1'($urandom), eb, 23'($urandom)),
           "R3 mixed stream");
      if (i % 9 == 8) idle(2);
    end
    drain("R3 mixed drain");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule